// File: doc/BRIEF.md
# Exception Prioritizer and Entry Controller

This block sits beside the execute stage of a 32-bit RISC core. Each cycle it looks at every pending exception condition: the reset request, a data abort, the fast and normal interrupt lines, a prefetch abort tagged on the instruction now in execute, and the undefined-instruction and software-interrupt conditions decoded from that instruction. The interrupt-disable bits of the current status word gate the two interrupt lines. It picks one winner by fixed priority. One cycle later it raises a single-cycle entry pulse. With that pulse it presents the vector address, the new status word, the new processor mode, and write strobes for the banked link register and the saved status register of the target mode.

A prefetch abort is not acted on when the fetch reports it. The abort travels as a tag beside the instruction through a small fetch-to-execute tag pipeline that advances with the core. It is taken only if that instruction reaches execute. Any exception entry flushes the tag pipeline. The block also gates the register-file write of a load, so that a data abort in the same cycle keeps the faulting load from writing its destination. The asynchronous reset input is released through a synchronizer, so the block leaves reset on a clock edge.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While `rst_n` is low, `entry_o`, `lr_we_o`, `spsr_we_o` and `fiq_bank_o` are 0. A reset request gives an entry with vector 0x00 and status word 0x000000D3 (mode 10011, I=1, F=1, T=0, all other bits zero), with no link or saved-status write.
- R2: When several conditions are pending, exactly one is taken, in this order from highest: reset, data abort, fast interrupt, normal interrupt, prefetch abort, undefined instruction, software interrupt.
- R3: Vector addresses are: reset 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, normal interrupt 0x18, fast interrupt 0x1C.
- R4: The normal interrupt is taken only while status bit 7 (I) is 0. The fast interrupt is taken only while status bit 6 (F) is 0. A masked line causes no entry.
- R5: Status bits [4:0] hold the mode. The target modes are: Supervisor 10011 for reset and software interrupt, Abort 10111 for both aborts, fast-interrupt mode 10001, normal-interrupt mode 10010, and Undefined 11011. Outside reset, the new status word is the old one with the mode replaced, bit 7 (I) set, bit 5 (T) cleared, and bit 6 (F) set only on fast-interrupt entry.
- R6: On every non-reset entry, `lr_we_o` and `spsr_we_o` pulse in the same cycle as `entry_o`. `lr_o` carries the `ret_addr` value and `spsr_o` the `cur_psr` value, both sampled in the cycle the exception was selected.
- R7: `fiq_bank_o` pulses with `entry_o` exactly when the fast interrupt is taken, selecting the bank that replaces r8 to r14.
- R8: An undefined-instruction exception is raised for a valid instruction in execute by `dec_undef`, by `dec_cond_nv`, or by `dec_cp_op` with `cp_absent` high. A coprocessor operation with `cp_absent` low raises nothing. Undefined wins over a simultaneous software interrupt.
- R9: A fetch abort is taken only after its instruction has advanced `PIPE_STAGES` times and sits in execute. While held in an earlier stage it causes no entry. If an entry flushes it first, it is never taken.
- R10: `wb_en_o` follows `load_wb_req` in the same cycle, except that it is 0 while `req_dabt` is high.
- R11: The entry for a condition selected in a cycle appears in the next cycle as a one-cycle pulse. In the cycle in which `entry_o` is high, no condition other than reset is selected.
- R12: After `rst_n` rises, the block ignores requests for `SYNC_STAGES` clock edges. With a request held from release, the first entry appears after edge `SYNC_STAGES`+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| req_reset | input | 1 | Core reset request |
| req_dabt | input | 1 | Data abort on the current data access |
| req_fiq | input | 1 | Fast interrupt line, active high |
| req_irq | input | 1 | Normal interrupt line, active high |
| cur_psr | input | 32 | Current status word |
| ret_addr | input | ADDR_W | Return address to save in the link register |
| fetch_valid | input | 1 | Fetch delivers an instruction |
| fetch_abort | input | 1 | That fetch was aborted |
| pipe_adv | input | 1 | Pipeline advances this cycle |
| dec_undef | input | 1 | Instruction in execute has an unknown opcode |
| dec_cond_nv | input | 1 | Instruction in execute uses the never condition |
| dec_cp_op | input | 1 | Instruction in execute is a coprocessor operation |
| cp_absent | input | 1 | No coprocessor accepted the operation |
| dec_swi | input | 1 | Instruction in execute is a software interrupt |
| load_wb_req | input | 1 | Load wants to write its destination register |
| entry_o | output | 1 | Exception entry pulse |
| vec_o | output | ADDR_W | Vector address |
| new_psr_o | output | 32 | Status word after entry |
| lr_we_o | output | 1 | Link register write strobe |
| lr_o | output | ADDR_W | Value for the link register |
| spsr_we_o | output | 1 | Saved status write strobe |
| spsr_o | output | 32 | Old status word for the saved status register |
| fiq_bank_o | output | 1 | Select fast-interrupt register bank |
| wb_en_o | output | 1 | Gated load writeback enable |

## Verification
The bench targets priority collisions: data abort against both interrupts, interrupt against a prefetch abort already in execute, and undefined against software interrupt. A wrong order shows as the wrong vector. It drives masked interrupt lines and checks for the missing vector, which a mis-wired mask would reveal. It holds an aborted fetch in decode, and separately flushes it with a higher-priority entry. An abort taken at fetch time, or taken after a flush, would show as an early or stray prefetch-abort entry. It also holds interrupts and reset across consecutive cycles, checks the exact release edge after reset, and checks the writeback gate, where an ungated design would let the faulting load write.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int PSR_W     = 32;
  localparam int MODE_W    = 5;
  localparam int VEC_W     = 5;
  localparam int NUM_SRC   = 7;
  localparam int SRC_IDX_W = $clog2(NUM_SRC);
  localparam int BIT_T     = 5;
  localparam int BIT_F     = 6;
  localparam int BIT_I     = 7;

  typedef enum logic [MODE_W-1:0] {
    MODE_USR = 5'b10000,
    MODE_FIQ = 5'b10001,
    MODE_IRQ = 5'b10010,
    MODE_SVC = 5'b10011,
    MODE_ABT = 5'b10111,
    MODE_UND = 5'b11011
  } cpu_mode_e;

  // Source index equals priority rank (0 = highest).
  typedef enum logic [SRC_IDX_W-1:0] {
    EK_RESET = 3'd0,
    EK_DABT  = 3'd1,
    EK_FIQ   = 3'd2,
    EK_IRQ   = 3'd3,
    EK_PABT  = 3'd4,
    EK_UNDEF = 3'd5,
    EK_SWI   = 3'd6
  } exc_kind_e;

  localparam logic [PSR_W-1:0] PSR_RESET = 32'h0000_00D3;
endpackage

// File: rtl/exc_rst_sync.sv
module exc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = (chain_q << 1) | STAGES'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/exc_pf_pipe.sv
module exc_pf_pipe #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic flush,
  input  logic in_valid,
  input  logic in_abort,
  output logic ex_valid,
  output logic ex_abort
);
  logic [STAGES-1:0] vld_q, vld_d;
  logic [STAGES-1:0] abt_q, abt_d;

  always_comb begin
    vld_d = vld_q;
    abt_d = abt_q;
    if (flush) begin
      vld_d = '0;
      abt_d = '0;
    end else if (adv) begin
      vld_d[0] = in_valid;
      abt_d[0] = in_valid & in_abort;
      for (int i = 1; i < STAGES; i++) begin
        vld_d[i] = vld_q[i-1];
        abt_d[i] = abt_q[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      abt_q <= '0;
    end else begin
      vld_q <= vld_d;
      abt_q <= abt_d;
    end
  end

  assign ex_valid = vld_q[STAGES-1];
  assign ex_abort = abt_q[STAGES-1];
endmodule

// File: rtl/exc_prio_sel.sv
module exc_prio_sel
  import exc_pkg::*;
(
  input  logic [NUM_SRC-1:0]   req,
  output logic                 any,
  output logic [SRC_IDX_W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = SRC_IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/exc_entry_map.sv
module exc_entry_map
  import exc_pkg::*;
(
  input  exc_kind_e        kind,
  input  logic [PSR_W-1:0] old_psr,
  output logic [VEC_W-1:0] vec,
  output logic [PSR_W-1:0] new_psr,
  output logic             save_ctx,
  output logic             fiq_bank
);
  cpu_mode_e mode;

  always_comb begin
    unique case (kind)
      EK_DABT:  begin vec = 5'h10; mode = MODE_ABT; end
      EK_FIQ:   begin vec = 5'h1C; mode = MODE_FIQ; end
      EK_IRQ:   begin vec = 5'h18; mode = MODE_IRQ; end
      EK_PABT:  begin vec = 5'h0C; mode = MODE_ABT; end
      EK_UNDEF: begin vec = 5'h04; mode = MODE_UND; end
      EK_SWI:   begin vec = 5'h08; mode = MODE_SVC; end
      default:  begin vec = 5'h00; mode = MODE_SVC; end
    endcase

    new_psr                = old_psr;
    new_psr[MODE_W-1:0]    = mode;
    new_psr[BIT_T]         = 1'b0;
    new_psr[BIT_I]         = 1'b1;
    if (kind == EK_FIQ) new_psr[BIT_F] = 1'b1;
    if (kind == EK_RESET) new_psr = PSR_RESET;

    save_ctx = (kind != EK_RESET);
    fiq_bank = (kind == EK_FIQ);
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int SYNC_STAGES = 2,
  parameter int PIPE_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_reset,
  input  logic              req_dabt,
  input  logic              req_fiq,
  input  logic              req_irq,
  input  logic [31:0]       cur_psr,
  input  logic [ADDR_W-1:0] ret_addr,
  input  logic              fetch_valid,
  input  logic              fetch_abort,
  input  logic              pipe_adv,
  input  logic              dec_undef,
  input  logic              dec_cond_nv,
  input  logic              dec_cp_op,
  input  logic              cp_absent,
  input  logic              dec_swi,
  input  logic              load_wb_req,
  output logic              entry_o,
  output logic [ADDR_W-1:0] vec_o,
  output logic [31:0]       new_psr_o,
  output logic              lr_we_o,
  output logic [ADDR_W-1:0] lr_o,
  output logic              spsr_we_o,
  output logic [31:0]       spsr_o,
  output logic              fiq_bank_o,
  output logic              wb_en_o
);
  localparam int VEC_PAD = ADDR_W - VEC_W;

  logic rst_sync_n;
  logic ex_valid, ex_abort;
  logic [NUM_SRC-1:0] src_req;
  logic sel_any;
  logic [SRC_IDX_W-1:0] sel_idx;
  exc_kind_e sel_kind;
  logic [VEC_W-1:0] map_vec;
  logic [PSR_W-1:0] map_psr;
  logic map_save, map_fiq;
  logic take;

  // Next-state / registered signals
  logic entry_d, entry_q;
  logic lr_we_d, lr_we_q;
  logic spsr_we_d, spsr_we_q;
  logic fiq_d, fiq_q;
  logic [ADDR_W-1:0] vec_q, lr_q;
  logic [PSR_W-1:0]  psr_q, spsr_q;

  exc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  exc_pf_pipe #(.STAGES(PIPE_STAGES)) u_pf_pipe (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .adv      (pipe_adv),
    .flush    (take),
    .in_valid (fetch_valid),
    .in_abort (fetch_abort),
    .ex_valid (ex_valid),
    .ex_abort (ex_abort)
  );

  always_comb begin
    src_req           = '0;
    src_req[EK_RESET] = req_reset;
    src_req[EK_DABT]  = req_dabt;
    src_req[EK_FIQ]   = req_fiq & ~cur_psr[BIT_F];
    src_req[EK_IRQ]   = req_irq & ~cur_psr[BIT_I];
    src_req[EK_PABT]  = ex_valid & ex_abort;
    src_req[EK_UNDEF] = ex_valid & (dec_undef | dec_cond_nv | (dec_cp_op & cp_absent));
    src_req[EK_SWI]   = ex_valid & dec_swi;
  end

  exc_prio_sel u_prio (
    .req (src_req),
    .any (sel_any),
    .idx (sel_idx)
  );

  assign sel_kind = exc_kind_e'(sel_idx);

  exc_entry_map u_map (
    .kind     (sel_kind),
    .old_psr  (cur_psr),
    .vec      (map_vec),
    .new_psr  (map_psr),
    .save_ctx (map_save),
    .fiq_bank (map_fiq)
  );

  // Entry cycle acts as the flush slot: only reset may be selected then.
  always_comb begin
    take      = sel_any & (~entry_q | (sel_kind == EK_RESET));
    entry_d   = take;
    lr_we_d   = take & map_save;
    spsr_we_d = take & map_save;
    fiq_d     = take & map_fiq;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      entry_q   <= 1'b0;
      lr_we_q   <= 1'b0;
      spsr_we_q <= 1'b0;
      fiq_q     <= 1'b0;
    end else begin
      entry_q   <= entry_d;
      lr_we_q   <= lr_we_d;
      spsr_we_q <= spsr_we_d;
      fiq_q     <= fiq_d;
    end
  end

  // Payload registers load only on a taken entry.
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vec_q  <= '0;
      psr_q  <= '0;
      lr_q   <= '0;
      spsr_q <= '0;
    end else if (take) begin
      vec_q  <= {{VEC_PAD{1'b0}}, map_vec};
      psr_q  <= map_psr;
      lr_q   <= ret_addr;
      spsr_q <= cur_psr;
    end
  end

  assign entry_o    = entry_q;
  assign vec_o      = vec_q;
  assign new_psr_o  = psr_q;
  assign lr_we_o    = lr_we_q;
  assign lr_o       = lr_q;
  assign spsr_we_o  = spsr_we_q;
  assign spsr_o     = spsr_q;
  assign fiq_bank_o = fiq_q;
  assign wb_en_o    = load_wb_req & ~req_dabt;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_reset,
  input logic              req_dabt,
  input logic              req_fiq,
  input logic [31:0]       cur_psr,
  input logic              entry_o,
  input logic [ADDR_W-1:0] vec_o,
  input logic [31:0]       new_psr_o,
  input logic              lr_we_o,
  input logic              spsr_we_o,
  input logic              fiq_bank_o,
  input logic              wb_en_o
);
  localparam logic [ADDR_W-1:0] VEC_IRQ = ADDR_W'(8'h18);

  // R6
  lr_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lr_we_o |-> (spsr_we_o && entry_o));

  // R4
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_o && vec_o == VEC_IRQ) |-> !$past(cur_psr[7]));

  // R2
  irq_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_o && vec_o == VEC_IRQ) |->
      (!$past(req_reset) && !$past(req_dabt) && !($past(req_fiq) && !$past(cur_psr[6]))));

  // R5
  psr_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_o |-> (new_psr_o[7] && !new_psr_o[5]));

  // R7
  fiq_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_bank_o |-> (entry_o && new_psr_o[4:0] == 5'b10001 && new_psr_o[6]));

  // R11
  no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_o && vec_o != '0) |=> (!entry_o || vec_o == '0));

  // R10
  wb_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_dabt |-> !wb_en_o);
endmodule

bind exc_entry_ctrl exc_entry_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_reset  (req_reset),
  .req_dabt   (req_dabt),
  .req_fiq    (req_fiq),
  .cur_psr    (cur_psr),
  .entry_o    (entry_o),
  .vec_o      (vec_o),
  .new_psr_o  (new_psr_o),
  .lr_we_o    (lr_we_o),
  .spsr_we_o  (spsr_we_o),
  .fiq_bank_o (fiq_bank_o),
  .wb_en_o    (wb_en_o)
);

// File: tb/exc_entry_ctrl_bench.sv
module exc_entry_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic req_reset, req_dabt, req_fiq, req_irq;
  logic [31:0] cur_psr;
  logic [ADDR_W-1:0] ret_addr;
  logic fetch_valid, fetch_abort, pipe_adv;
  logic dec_undef, dec_cond_nv, dec_cp_op, cp_absent, dec_swi, load_wb_req;
  logic entry_o, lr_we_o, spsr_we_o, fiq_bank_o, wb_en_o;
  logic [ADDR_W-1:0] vec_o, lr_o;
  logic [31:0] new_psr_o, spsr_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_entry_ctrl u_exc_entry_ctrl (
    .clk(clk), .rst_n(rst_n), .req_reset(req_reset), .req_dabt(req_dabt),
    .req_fiq(req_fiq), .req_irq(req_irq), .cur_psr(cur_psr), .ret_addr(ret_addr),
    .fetch_valid(fetch_valid), .fetch_abort(fetch_abort), .pipe_adv(pipe_adv),
    .dec_undef(dec_undef), .dec_cond_nv(dec_cond_nv), .dec_cp_op(dec_cp_op),
    .cp_absent(cp_absent), .dec_swi(dec_swi), .load_wb_req(load_wb_req),
    .entry_o(entry_o), .vec_o(vec_o), .new_psr_o(new_psr_o), .lr_we_o(lr_we_o),
    .lr_o(lr_o), .spsr_we_o(spsr_we_o), .spsr_o(spsr_o), .fiq_bank_o(fiq_bank_o),
    .wb_en_o(wb_en_o)
  );

  // Kind codes: 0 reset, 1 dabt, 2 fiq, 3 irq, 4 pabt, 5 undef, 6 swi
  function automatic logic [31:0] vec_of(int k);
    case (k)
      0: return 32'h00; 1: return 32'h10; 2: return 32'h1C; 3: return 32'h18;
      4: return 32'h0C; 5: return 32'h04; default: return 32'h08;
    endcase
  endfunction

  function automatic logic [4:0] mode_of(int k);
    case (k)
      0, 6: return 5'b10011;
      1, 4: return 5'b10111;
      2: return 5'b10001;
      3: return 5'b10010;
      default: return 5'b11011;
    endcase
  endfunction

  function automatic logic [31:0] model_psr(int k, logic [31:0] old);
    logic [31:0] r;
    if (k == 0) return 32'h0000_00D3;
    r = old;
    r[4:0] = mode_of(k);
    r[5] = 1'b0;
    r[7] = 1'b1;
    if (k == 2) r[6] = 1'b1;
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_inputs();
    req_reset = 0; req_dabt = 0; req_fiq = 0; req_irq = 0;
    fetch_valid = 0; fetch_abort = 0; pipe_adv = 0;
    dec_undef = 0; dec_cond_nv = 0; dec_cp_op = 0; cp_absent = 0; dec_swi = 0;
    load_wb_req = 0;
  endtask

  task automatic expect_none(string tag);
    check({tag, " entry"}, 32'(entry_o), 32'd0);
    check({tag, " lr_we"}, 32'(lr_we_o), 32'd0);
    check({tag, " spsr_we"}, 32'(spsr_we_o), 32'd0);
    check({tag, " fiq_bank"}, 32'(fiq_bank_o), 32'd0);
  endtask

  task automatic expect_entry(string tag, int k, logic [31:0] old, logic [31:0] ret);
    check({tag, " entry"}, 32'(entry_o), 32'd1);
    check({tag, " vector"}, vec_o, vec_of(k));
    check({tag, " new status"}, new_psr_o, model_psr(k, old));
    check({tag, " lr_we"}, 32'(lr_we_o), 32'(k != 0));
    check({tag, " spsr_we"}, 32'(spsr_we_o), 32'(k != 0));
    if (k != 0) begin
      check({tag, " lr value"}, lr_o, ret);
      check({tag, " spsr value"}, spsr_o, old);
    end
    check({tag, " fiq_bank"}, 32'(fiq_bank_o), 32'(k == 2));
  endtask

  task automatic drain();
    clear_inputs();
    tick();
    tick();
  endtask

  // Moves one instruction into execute over two advances, checking no early entry.
  task automatic push_insn(logic abort, string tag);
    fetch_valid = 1; fetch_abort = abort; pipe_adv = 1;
    tick();
    expect_none({tag, " R9 at decode"});
    fetch_valid = 0; fetch_abort = 0;
    tick();
    expect_none({tag, " R9 reaching execute"});
    pipe_adv = 0;
  endtask

  task automatic t_reset_and_release();
    rst_n = 0;
    clear_inputs();
    cur_psr = 32'h0000_0010; ret_addr = 32'h0;
    req_irq = 1;
    tick(); tick(); tick();
    expect_none("R1 in reset");
    rst_n = 1;
    tick();
    expect_none("R12 edge1");
    tick();
    expect_none("R12 edge2");
    tick();
    expect_entry("R12 edge3", 3, 32'h0000_0010, 32'h0);
    drain();
  endtask

  task automatic t_reset_request();
    cur_psr = 32'hF000_0030; ret_addr = 32'h0000_1234;
    req_reset = 1; req_dabt = 1; req_fiq = 1; req_irq = 1;
    tick();
    expect_entry("R1 R2 reset wins", 0, cur_psr, ret_addr);
    tick();
    check("R11 held reset re-enters", 32'(entry_o), 32'd1);
    check("R11 held reset vector", vec_o, 32'h0);
    drain();
  endtask

  task automatic t_single_sources();
    cur_psr = 32'h6000_0010; ret_addr = 32'h0000_0100;
    req_dabt = 1;
    tick();
    expect_entry("R3 dabt", 1, 32'h6000_0010, 32'h100);
    drain();
    cur_psr = 32'h8000_0030; ret_addr = 32'h0000_0204;
    req_fiq = 1;
    tick();
    expect_entry("R5 R7 fiq", 2, 32'h8000_0030, 32'h204);
    drain();
    cur_psr = 32'hA000_0030; ret_addr = 32'h0000_0308;
    req_irq = 1;
    tick();
    expect_entry("R5 R6 irq", 3, 32'hA000_0030, 32'h308);
    drain();
  endtask

  task automatic t_priority();
    cur_psr = 32'h0000_0010; ret_addr = 32'h40;
    req_dabt = 1; req_fiq = 1; req_irq = 1;
    tick();
    expect_entry("R2 dabt over interrupts", 1, 32'h10, 32'h40);
    drain();
    req_fiq = 1; req_irq = 1;
    tick();
    expect_entry("R2 fiq over irq", 2, 32'h10, 32'h40);
    drain();
    push_insn(1'b1, "R2 pabt");
    req_irq = 1;
    tick();
    expect_entry("R2 irq over pabt", 3, 32'h10, 32'h40);
    clear_inputs();
    tick(); tick(); tick();
    expect_none("R9 flushed pabt stays dropped");
  endtask

  task automatic t_masking();
    ret_addr = 32'h80;
    cur_psr = 32'h0000_0090;
    req_irq = 1;
    tick(); tick();
    expect_none("R4 irq masked by I");
    drain();
    cur_psr = 32'h0000_0050;
    req_fiq = 1;
    tick(); tick();
    expect_none("R4 fiq masked by F");
    req_irq = 1;
    tick();
    expect_entry("R4 irq taken while fiq masked", 3, 32'h50, 32'h80);
    drain();
  endtask

  task automatic t_prefetch_abort();
    cur_psr = 32'h0000_0010; ret_addr = 32'h0C0;
    fetch_valid = 1; fetch_abort = 1; pipe_adv = 1;
    tick();
    fetch_valid = 0; fetch_abort = 0; pipe_adv = 0;
    for (int i = 0; i < 4; i++) begin
      tick();
      expect_none("R9 held in decode");
    end
    pipe_adv = 1;
    tick();
    expect_none("R9 just reached execute");
    pipe_adv = 0;
    tick();
    expect_entry("R9 pabt in execute", 4, 32'h10, 32'h0C0);
    drain();
    // Abort in decode flushed by a data abort entry.
    fetch_valid = 1; fetch_abort = 1; pipe_adv = 1;
    tick();
    fetch_valid = 0; fetch_abort = 0; pipe_adv = 0;
    req_dabt = 1;
    tick();
    expect_entry("R9 dabt flushes pending pabt", 1, 32'h10, 32'h0C0);
    clear_inputs();
    pipe_adv = 1;
    tick(); tick(); tick();
    expect_none("R9 flushed abort never taken");
    drain();
  endtask

  task automatic t_undefined();
    cur_psr = 32'h2000_0010; ret_addr = 32'h200;
    push_insn(1'b0, "R8 nv");
    dec_cond_nv = 1;
    tick();
    expect_entry("R8 never condition", 5, 32'h2000_0010, 32'h200);
    drain();
    push_insn(1'b0, "R8 cp");
    dec_cp_op = 1; cp_absent = 1;
    tick();
    expect_entry("R8 coprocessor absent", 5, 32'h2000_0010, 32'h200);
    drain();
    push_insn(1'b0, "R8 cp ok");
    dec_cp_op = 1; cp_absent = 0;
    tick(); tick();
    expect_none("R8 coprocessor accepted");
    drain();
    push_insn(1'b0, "R8 both");
    dec_undef = 1; dec_swi = 1;
    tick();
    expect_entry("R8 undef over swi", 5, 32'h2000_0010, 32'h200);
    drain();
    push_insn(1'b0, "R3 swi");
    dec_swi = 1;
    tick();
    expect_entry("R3 swi", 6, 32'h2000_0010, 32'h200);
    drain();
  endtask

  task automatic t_back_to_back();
    cur_psr = 32'h0000_0010; ret_addr = 32'h300;
    req_irq = 1;
    tick();
    check("R11 first entry", 32'(entry_o), 32'd1);
    tick();
    check("R11 entry cycle blocks", 32'(entry_o), 32'd0);
    tick();
    check("R11 entry resumes", 32'(entry_o), 32'd1);
    drain();
  endtask

  task automatic t_writeback();
    cur_psr = 32'h0000_0010; ret_addr = 32'h400;
    load_wb_req = 1;
    #1;
    check("R10 load writes", 32'(wb_en_o), 32'd1);
    req_dabt = 1;
    #1;
    check("R10 dabt suppresses write", 32'(wb_en_o), 32'd0);
    tick();
    expect_entry("R10 dabt entry", 1, 32'h10, 32'h400);
    drain();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    clear_inputs();
    cur_psr = '0;
    ret_addr = '0;
    @(negedge clk);
    t_reset_and_release();
    t_reset_request();
    t_single_sources();
    t_priority();
    t_masking();
    t_prefetch_abort();
    t_undefined();
    t_back_to_back();
    t_writeback();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule